// File: doc/BRIEF.md
# Reconfigurable 4/8-Point Approximate DCT Datapath

This block is a pipelined, multiplier-free one-dimensional integer DCT engine for video transform stages. It has eight signed input lanes. Each accepted input word is processed in one of two modes. In the first mode, lanes 0..3 and lanes 4..7 are treated as two unrelated 4-point blocks and each is transformed on its own. In the second mode, all eight lanes form one 8-point block.

Both modes use the same pair of 4-point kernels. Each kernel forms sum and difference butterflies on its operands. It then scales them by the constants 64, 83 and 36 using only shifts and adds, and combines the products. In 8-point mode, a front butterfly first folds the eight lanes into mirrored sums and differences. The sums go to one kernel and the differences to the other. An output multiplexer then interleaves the two kernel results into natural coefficient order.

A size-dependent rounding right shift and a saturation to the output width finish the result. A valid bit travels with every word, and the select bit is captured with its own data. This lets the mode change from one word to the next without bubbles.

Top module: `approx_dct48`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` becomes 0 and `out_data` becomes 0. After reset, `out_valid` stays 0 until a valid input has travelled the full pipeline.
- R2: Latency is exactly 3 clock edges. `out_valid` at a sample equals `in_valid` three edges earlier. Every accepted word yields exactly one output word, and gaps in `in_valid` pass through unchanged.
- R3: With `in_sel8`=0, each half is transformed on its own. Let u0..u3 be lanes 0..3, or lanes 4..7 for the other half. The raw results are z0=64(u0+u1+u2+u3), z1=83(u0-u3)+36(u1-u2), z2=64(u0+u3-u1-u2) and z3=36(u0-u3)-83(u1-u2). Output lane k of the half carries zk.
- R4: In 4-point mode the halves are independent. Output lanes 4..7 depend only on input lanes 4..7, and output lanes 0..3 depend only on input lanes 0..3.
- R5: With `in_sel8`=1, output lane 2k carries raw result zk of the R3 kernel applied to a(i)=x(i)+x(7-i), for i=0..3.
- R6: With `in_sel8`=1, output lane 2k+1 carries raw result zk of the R3 kernel applied to b(i)=x(i)-x(7-i). Mirror-symmetric inputs therefore give zero odd lanes.
- R7: Each raw result is rounded by adding 2^(s-1) and then shifting right arithmetically by s. Here s=1 in 4-point mode and s=2 in 8-point mode, so ties round toward positive infinity.
- R8: Rounded results outside [-32768, 32767] are clamped to the nearest bound.
- R9: The mode bit is taken with each word's data. Back-to-back words in alternating modes are each transformed in their own mode.
- R10: A valid all-zero input word produces an all-zero output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_sel8 | input | 1 | 0: two 4-point blocks, 1: one 8-point block |
| in_data | input | 128 | Eight signed 16-bit samples, lane i at bits [16i+15:16i] |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 128 | Eight signed 16-bit coefficients, lane i at bits [16i+15:16i] |

## Verification
A mode bit that drifts away from its data in the pipeline shows up three edges after a mode change. Its rounding offset is wrong by one or two LSBs, and the lanes come out interleaved where they should be in halves, or the reverse. Back-to-back alternating modes therefore expose it on the very first word. A wrong sign or coefficient in a shift-add unit corrupts only the odd-indexed results of one kernel. Single-lane impulses show this in the first output word. A stale butterfly register breaks the mirror-symmetry and zero-input rules right away.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int LANES = 8;
  localparam int HALF  = LANES / 2;
  typedef enum logic { SIZE4 = 1'b0, SIZE8 = 1'b1 } size_e;
endpackage

// File: rtl/dct_front.sv
// Operand selection: mirrored butterflies in 8-point mode, raw lanes otherwise.
module dct_front #(
  parameter int IN_W = 16,
  parameter int OP_W = IN_W + 1
) (
  input  logic                                sel8,
  input  logic [dct_pkg::LANES*IN_W-1:0]      x_flat,
  output logic [dct_pkg::LANES*OP_W-1:0]      op_flat
);
  localparam int NL = dct_pkg::LANES;
  localparam int NH = dct_pkg::HALF;

  for (genvar i = 0; i < NH; i++) begin : g_fold
    logic signed [IN_W-1:0] near_s, far_s, upper_s;
    logic signed [OP_W-1:0] fold_sum, fold_dif;
    assign near_s   = $signed(x_flat[i*IN_W +: IN_W]);
    assign far_s    = $signed(x_flat[(NL-1-i)*IN_W +: IN_W]);
    assign upper_s  = $signed(x_flat[(NH+i)*IN_W +: IN_W]);
    assign fold_sum = OP_W'(near_s) + OP_W'(far_s);
    assign fold_dif = OP_W'(near_s) - OP_W'(far_s);
    // kernel A operand i, kernel B operand i
    assign op_flat[i*OP_W +: OP_W]      = sel8 ? fold_sum : OP_W'(near_s);
    assign op_flat[(NH+i)*OP_W +: OP_W] = sel8 ? fold_dif : OP_W'(upper_s);
  end
endmodule

// File: rtl/dct_cmul.sv
// Constant multiplier built from shifted copies of the operand, one per set bit.
module dct_cmul #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 26,
  parameter int COEF  = 83
) (
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] p
);
  localparam int CW = $clog2(COEF + 1);
  localparam logic [CW-1:0] CBITS = CW'(COEF);

  always_comb begin
    p = '0;
    for (int k = 0; k < CW; k++) begin
      if (CBITS[k]) p = p + (OUT_W'(x) <<< k);
    end
  end
endmodule

// File: rtl/dct4_kernel.sv
// 4-point shift-add kernel: butterfly register, product register, combinational sums.
module dct4_kernel #(
  parameter int OP_W  = 17,
  parameter int ACC_W = 26
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [4*OP_W-1:0]     u_flat,
  output logic [4*ACC_W-1:0]    z_flat
);
  localparam int BW = OP_W + 1;

  logic signed [OP_W-1:0] u [4];
  for (genvar j = 0; j < 4; j++) begin : g_unpack
    assign u[j] = $signed(u_flat[j*OP_W +: OP_W]);
  end

  // stage 1: input butterflies
  logic signed [BW-1:0] ev0_q, ev1_q, od0_q, od1_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ev0_q <= '0; ev1_q <= '0; od0_q <= '0; od1_q <= '0;
    end else begin
      ev0_q <= BW'(u[0]) + BW'(u[3]);
      ev1_q <= BW'(u[1]) + BW'(u[2]);
      od0_q <= BW'(u[0]) - BW'(u[3]);
      od1_q <= BW'(u[1]) - BW'(u[2]);
    end
  end

  // stage 2: scaling by 64 (wiring) and by 83/36 (shift-add)
  logic signed [ACC_W-1:0] dc_sum, dc_dif;
  assign dc_sum = (ACC_W'(ev0_q) + ACC_W'(ev1_q)) <<< 6;
  assign dc_dif = (ACC_W'(ev0_q) - ACC_W'(ev1_q)) <<< 6;

  logic signed [ACC_W-1:0] prod   [4];
  logic signed [ACC_W-1:0] prod_q [4];
  // product p: 0 -> 83*od0, 1 -> 36*od1, 2 -> 36*od0, 3 -> 83*od1
  for (genvar p = 0; p < 4; p++) begin : g_prod
    localparam int C = (p == 0 || p == 3) ? 83 : 36;
    logic signed [BW-1:0] src;
    if (p % 2 == 0) begin : g_src0
      assign src = od0_q;
    end else begin : g_src1
      assign src = od1_q;
    end
    dct_cmul #(.IN_W(BW), .OUT_W(ACC_W), .COEF(C)) u_mul (.x(src), .p(prod[p]));
  end

  logic signed [ACC_W-1:0] dc_sum_q, dc_dif_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      dc_sum_q <= '0;
      dc_dif_q <= '0;
      for (int p = 0; p < 4; p++) prod_q[p] <= '0;
    end else begin
      dc_sum_q <= dc_sum;
      dc_dif_q <= dc_dif;
      for (int p = 0; p < 4; p++) prod_q[p] <= prod[p];
    end
  end

  // output adders (registered in the top)
  assign z_flat[0*ACC_W +: ACC_W] = dc_sum_q;
  assign z_flat[1*ACC_W +: ACC_W] = prod_q[0] + prod_q[1];
  assign z_flat[2*ACC_W +: ACC_W] = dc_dif_q;
  assign z_flat[3*ACC_W +: ACC_W] = prod_q[2] - prod_q[3];
endmodule

// File: rtl/dct_out_stage.sv
// Reorder into natural coefficient order, round-shift by mode, saturate.
module dct_out_stage #(
  parameter int ACC_W = 26,
  parameter int OUT_W = 16,
  parameter int SH4   = 1,
  parameter int SH8   = 2
) (
  input  logic                               sel8,
  input  logic [4*ACC_W-1:0]                 za_flat,
  input  logic [4*ACC_W-1:0]                 zb_flat,
  output logic [dct_pkg::LANES*OUT_W-1:0]    y_flat
);
  localparam int RW = ACC_W + 1;
  localparam logic signed [RW-1:0] RND4   = RW'(1) <<< (SH4 - 1);
  localparam logic signed [RW-1:0] RND8   = RW'(1) <<< (SH8 - 1);
  localparam logic signed [RW-1:0] SAT_HI = RW'(2**(OUT_W-1) - 1);
  localparam logic signed [RW-1:0] SAT_LO = -SAT_HI - RW'(1);

  for (genvar i = 0; i < dct_pkg::LANES; i++) begin : g_lane
    localparam bit   IN_B8 = (i % 2) == 1;
    localparam int   IX8   = i / 2;
    localparam bit   IN_B4 = i >= dct_pkg::HALF;
    localparam int   IX4   = i % dct_pkg::HALF;
    logic signed [ACC_W-1:0] pick8, pick4, pick;
    logic signed [RW-1:0]    biased, shifted;
    logic signed [OUT_W-1:0] clamped;

    assign pick8 = IN_B8 ? $signed(zb_flat[IX8*ACC_W +: ACC_W]) : $signed(za_flat[IX8*ACC_W +: ACC_W]);
    assign pick4 = IN_B4 ? $signed(zb_flat[IX4*ACC_W +: ACC_W]) : $signed(za_flat[IX4*ACC_W +: ACC_W]);
    assign pick  = sel8 ? pick8 : pick4;

    assign biased  = RW'(pick) + (sel8 ? RND8 : RND4);
    assign shifted = sel8 ? (biased >>> SH8) : (biased >>> SH4);

    always_comb begin
      if (shifted > SAT_HI)      clamped = SAT_HI[OUT_W-1:0];
      else if (shifted < SAT_LO) clamped = SAT_LO[OUT_W-1:0];
      else                       clamped = shifted[OUT_W-1:0];
    end
    assign y_flat[i*OUT_W +: OUT_W] = clamped;
  end
endmodule

// File: rtl/approx_dct48.sv
module approx_dct48
  import dct_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int SH4   = 1,
  parameter int SH8   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sel8,
  input  logic [LANES*IN_W-1:0]   in_data,
  output logic                    out_valid,
  output logic [LANES*OUT_W-1:0]  out_data
);
  localparam int OP_W  = IN_W + 1;
  localparam int ACC_W = IN_W + 10;

  logic [LANES*OP_W-1:0] op_flat;
  dct_front #(.IN_W(IN_W), .OP_W(OP_W)) u_front (
    .sel8(in_sel8), .x_flat(in_data), .op_flat(op_flat)
  );

  logic [2*4*ACC_W-1:0] z_all;
  for (genvar g = 0; g < 2; g++) begin : g_kern
    dct4_kernel #(.OP_W(OP_W), .ACC_W(ACC_W)) u_kern (
      .clk(clk), .rst(rst),
      .u_flat(op_flat[g*4*OP_W +: 4*OP_W]),
      .z_flat(z_all[g*4*ACC_W +: 4*ACC_W])
    );
  end

  // control travelling with the data through the two kernel stages
  logic  vld_s1, vld_s2;
  size_e size_s1, size_s2;
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_s1 <= 1'b0; vld_s2 <= 1'b0;
      size_s1 <= SIZE4; size_s2 <= SIZE4;
    end else begin
      vld_s1 <= in_valid;
      vld_s2 <= vld_s1;
      size_s1 <= size_e'(in_sel8);
      size_s2 <= size_s1;
    end
  end

  logic [LANES*OUT_W-1:0] y_next;
  dct_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH4(SH4), .SH8(SH8)) u_out (
    .sel8(size_s2 == SIZE8),
    .za_flat(z_all[0 +: 4*ACC_W]),
    .zb_flat(z_all[4*ACC_W +: 4*ACC_W]),
    .y_flat(y_next)
  );

  // stage 3: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_s2;
      out_data  <= y_next;
    end
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               in_valid,
  input logic                               in_sel8,
  input logic [dct_pkg::LANES*IN_W-1:0]     in_data,
  input logic                               out_valid,
  input logic [dct_pkg::LANES*OUT_W-1:0]    out_data
);
  localparam int NL = dct_pkg::LANES;
  localparam int NH = dct_pkg::HALF;

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic in_zero, hi_zero, sym, odd_zero, out_hi_zero;
  assign in_zero     = (in_data == '0);
  assign hi_zero     = (in_data[NL*IN_W-1:NH*IN_W] == '0);
  assign out_hi_zero = (out_data[NL*OUT_W-1:NH*OUT_W] == '0);
  always_comb begin
    sym = 1'b1;
    odd_zero = 1'b1;
    for (int i = 0; i < NH; i++) begin
      if (in_data[i*IN_W +: IN_W] != in_data[(NL-1-i)*IN_W +: IN_W]) sym = 1'b0;
      if (out_data[(2*i+1)*OUT_W +: OUT_W] != '0) odd_zero = 1'b0;
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd3) |-> !out_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_zero_in_zero_out_R10: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(in_valid && in_zero, 3)) |-> (out_data == '0));

  assert_half_isolation_R4: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(in_valid && !in_sel8 && hi_zero, 3)) |-> out_hi_zero);

  assert_symmetric_odd_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(in_valid && in_sel8 && sym, 3)) |-> odd_zero);
endmodule

bind approx_dct48 dct_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dct_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel8(in_sel8),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_approx_dct48.sv
module test_approx_dct48;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_sel8 = 1'b0;
  logic [8*W-1:0] in_data = '0;
  logic out_valid;
  logic [8*W-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  approx_dct48 i_approx_dct48 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel8(in_sel8),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // expected pipeline contents: slot 2 is what the output shows now
  bit    pv [3];
  int    pd [3][8];
  string pt [3];

  function automatic int rnd_sat(int v, int sh);
    int r;
    r = (v + (1 << (sh - 1))) >>> sh;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic void kern(input int u[4], output int z[4]);
    z[0] = 64 * (u[0] + u[1] + u[2] + u[3]);
    z[1] = 83 * (u[0] - u[3]) + 36 * (u[1] - u[2]);
    z[2] = 64 * (u[0] + u[3] - u[1] - u[2]);
    z[3] = 36 * (u[0] - u[3]) - 83 * (u[1] - u[2]);
  endfunction

  function automatic void expect_word(input bit m8, input int x[8], output int e[8]);
    int u[4], v[4], za[4], zb[4];
    for (int i = 0; i < 4; i++) begin
      if (m8) begin
        u[i] = x[i] + x[7-i];
        v[i] = x[i] - x[7-i];
      end else begin
        u[i] = x[i];
        v[i] = x[4+i];
      end
    end
    kern(u, za);
    kern(v, zb);
    for (int i = 0; i < 4; i++) begin
      if (m8) begin
        e[2*i]   = rnd_sat(za[i], 2);   // R5
        e[2*i+1] = rnd_sat(zb[i], 2);   // R6
      end else begin
        e[i]     = rnd_sat(za[i], 1);   // R3
        e[4+i]   = rnd_sat(zb[i], 1);
      end
    end
  endfunction

  task automatic compare_now();
    bit bad;
    n_cmp++;
    if (out_valid !== pv[2]) begin
      n_bad++;
      $display("FAIL R2 out_valid: got %0b expected %0b", out_valid, pv[2]);
    end
    if (pv[2]) begin
      n_cmp++;
      bad = 0;
      for (int i = 0; i < 8; i++) begin
        int got;
        got = int'($signed(out_data[i*W +: W]));
        if (got != pd[2][i]) begin
          bad = 1;
          $display("FAIL %s lane %0d: got %0d expected %0d", pt[2], i, got, pd[2][i]);
        end
      end
      if (bad) n_bad++;
    end
  endtask

  task automatic step(input bit v, input bit m8, input int x[8], input string tag);
    int e[8];
    in_valid = v;
    in_sel8  = m8;
    for (int i = 0; i < 8; i++) in_data[i*W +: W] = x[i][W-1:0];
    expect_word(m8, x, e);
    @(posedge clk);
    pv[2] = pv[1]; pd[2] = pd[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
    pv[0] = v;     pd[0] = e;     pt[0] = tag;
    @(negedge clk);
    compare_now();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, '{0,0,0,0,0,0,0,0}, "R2");
  endtask

  initial begin
    for (int s = 0; s < 3; s++) begin
      pv[s] = 0; pt[s] = "R1";
      for (int i = 0; i < 8; i++) pd[s][i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got valid=%0b data=%h expected 0/0", out_valid, out_data);
    end
    rst = 1'b0;
    idle(3);  // R1: stays quiet

    // R3: plain 4-point blocks
    step(1, 0, '{1,2,3,4,5,6,7,8}, "R3");
    step(1, 0, '{100,-50,25,-300,7,7,7,7}, "R3");
    // R7: rounding of impulses, positive and negative ties
    step(1, 0, '{1,0,0,0,-1,0,0,0}, "R7");
    step(1, 1, '{1,0,0,0,0,0,0,0}, "R7");
    step(1, 1, '{-1,0,0,0,0,0,0,-3}, "R7");
    // R5 / R6: 8-point composition, symmetric and antisymmetric
    step(1, 1, '{10,20,30,40,40,30,20,10}, "R6");
    step(1, 1, '{5,-6,7,-8,8,-7,6,-5}, "R5");
    step(1, 1, '{1,2,3,4,5,6,7,8}, "R5");
    // R4: one half held, the other varied
    step(1, 0, '{9,-9,4,2,0,0,0,0}, "R4");
    step(1, 0, '{9,-9,4,2,3000,-2000,1000,-500}, "R4");
    step(1, 0, '{0,0,0,0,3000,-2000,1000,-500}, "R4");
    // R8: saturation both ways
    step(1, 1, '{32767,32767,32767,32767,32767,32767,32767,32767}, "R8");
    step(1, 1, '{-32768,-32768,-32768,-32768,-32768,-32768,-32768,-32768}, "R8");
    step(1, 0, '{32767,-32768,32767,-32768,-32768,-32768,-32768,-32768}, "R8");
    // R10: zero word
    step(1, 1, '{0,0,0,0,0,0,0,0}, "R10");
    step(1, 0, '{0,0,0,0,0,0,0,0}, "R10");
    // R9: mode alternates every word
    for (int k = 0; k < 8; k++)
      step(1, k[0], '{3*k,-k,17,k*k,-40,k,2,-k-1}, "R9");
    // R2: bubbles
    step(1, 0, '{1,1,1,1,2,2,2,2}, "R2");
    idle(1);
    step(1, 1, '{4,3,2,1,1,2,3,4}, "R2");
    idle(2);
    step(1, 0, '{-7,0,7,0,0,7,0,-7}, "R2");
    // random words, random mode and valid
    for (int k = 0; k < 60; k++) begin
      int x[8];
      bit m8, v;
      for (int i = 0; i < 8; i++) x[i] = int'($urandom_range(65535)) - 32768;
      m8 = 1'($urandom_range(1));
      v  = ($urandom_range(3) != 0);
      step(v, m8, x, m8 ? "R5/R6" : "R3");
    end
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion expected end of run");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule